// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block drives the digital side of a successive-approximation analog-to-digital converter. A start request comes from one of three sources: a software start line, a timer event or an external trigger. A configuration field picks which of these is live. After a start, the block holds the sample-and-hold for a sample time that is set separately for each channel. It then resolves a 12-bit code, deciding one bit per clock cycle from the most significant bit downward. The trial code goes out on a parallel bus to an external DAC. A single-bit comparator input tells the block whether the held input is at or above that trial code.

The block can convert one channel, or it can scan up to four channels back to back in the order of a programmed slot list. Each finished conversion places the code and its channel number in a result register and raises an end-of-conversion flag. Software lowers the flag by reading or by writing a clear strobe. A result that lands while the flag is still up raises a sticky overrun bit. Configuration inputs are assumed stable while `busy` is high.

Top module: `sar_conv_ctrl`

## Requirements
- R1: An accepted start raises `busy` and `sh_hold` on the same clock edge. `sh_hold` stays high for the whole sample phase, and no trial code is applied to the comparison before that phase ends. `ch_sel` shows the channel being converted from the sample phase through the last bit decision.
- R2: Each channel's sample time is a 9-bit field at bits [c*9 +: 9] of `cfg_smp_time`. The sample phase lasts exactly that many cycles after the value is clamped into the range 3 to 480 (values 0..2 give 3 cycles, values above 480 give 480 cycles).
- R3: In the first decision cycle `dac_code` is 0x800. During the decision for bit i, `dac_code` holds the bits already resolved above i, with bit i set and all lower bits clear. A high `cmp_in` (held input at or above the trial code) keeps bit i; a low `cmp_in` clears it.
- R4: Each channel takes exactly S + 12 busy cycles, where S is its clamped sample time. With an ideal comparator the result equals the input code for every value from 0 to 4095.
- R5: `cfg_trig_src` selects the start source: 0 means `sw_start`, 1 means `tmr_evt`, 2 means `ext_trig`, and 3 means none. A pulse on a source that is not selected does not start a conversion.
- R6: Start pulses that arrive while `busy` is high are ignored. `busy` stays high without a gap from the start until the last channel of the sequence has completed.
- R7: Scan slot k holds a 4-bit channel number at bits [k*4 +: 4] of `cfg_seq_list`. The slots are converted back to back in order 0, 1, 2, .... `cfg_seq_len` sets the slot count from 1 to 4; a value of 0 counts as 1 and a value above 4 counts as 4.
- R8: When a conversion completes, `result`, `result_ch` and `eoc` are updated on the same clock edge. A one-cycle `rd_result` pulse or a one-cycle `eoc_clr` pulse clears `eoc`.
- R9: If a conversion completes while `eoc` is still high and no clear is given in that cycle, `ovr` is set and stays set. `ovr` is cleared only by `eoc_clr`.
- R10: If a conversion completes in the same cycle as an `rd_result` pulse, `eoc` stays high, `ovr` keeps its value, and `result` holds the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_trig_src | input | 2 | Start source select (0 software, 1 timer, 2 external, 3 none) |
| sw_start | input | 1 | Software start pulse |
| tmr_evt | input | 1 | Timer event pulse |
| ext_trig | input | 1 | External trigger pulse |
| cfg_seq_len | input | 3 | Number of scan slots |
| cfg_seq_list | input | 16 | Four 4-bit slot channel numbers |
| cfg_smp_time | input | 144 | Sixteen 9-bit per-channel sample times |
| cmp_in | input | 1 | Comparator: held input at or above `dac_code` |
| rd_result | input | 1 | Result read strobe |
| eoc_clr | input | 1 | Flag clear strobe (clears `eoc` and `ovr`) |
| sh_hold | output | 1 | Sample-and-hold tracking enable |
| dac_code | output | 12 | Trial code to the DAC |
| ch_sel | output | 4 | Channel currently being converted |
| busy | output | 1 | Conversion sequence in progress |
| eoc | output | 1 | End-of-conversion flag |
| ovr | output | 1 | Overrun flag |
| result | output | 12 | Last converted code |
| result_ch | output | 4 | Channel of the last converted code |

## Verification
Two events can land on the same clock edge: a completed conversion setting the end-of-conversion flag, and a software read clearing it. The bench leaves the flag high from one conversion. It then counts busy cycles in a second conversion so that the `rd_result` pulse falls exactly in the final bit-decision cycle. The result counts as correct only if the flag stays high, the overrun bit stays low and the new code is visible. A companion case skips the read altogether, and there the overrun bit must rise.

// File: rtl/sar_conv_pkg.sv
// Shared types for the successive-approximation conversion sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sar_conv_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SAMPLE  = 2'd1,
        PH_RESOLVE = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        TRG_SOFT  = 2'd0,
        TRG_TIMER = 2'd1,
        TRG_EXT   = 2'd2,
        TRG_OFF   = 2'd3
    } trig_src_t;
endpackage

// File: rtl/sar_trig_mux.sv
// Start-source selector: passes only the chosen start line, and only while
// the sequencer is idle. Assumes start lines are synchronous to clk.
module sar_trig_mux
    import sar_conv_pkg::*;
(
    input  logic [1:0] src_sel,
    input  logic       sw_start,
    input  logic       tmr_evt,
    input  logic       ext_trig,
    input  logic       idle,
    output logic       start
);
    logic picked;

    // Choose the live start line by source code.
    always_comb begin
        case (trig_src_t'(src_sel))
            TRG_SOFT:  picked = sw_start;
            TRG_TIMER: picked = tmr_evt;
            TRG_EXT:   picked = ext_trig;
            default:   picked = 1'b0;
        endcase
    end

    // Requests seen while a sequence runs are dropped here.
    assign start = picked & idle;
endmodule

// File: rtl/sar_sequencer.sv
// Phase sequencer: walks the scan slot list, times each sample phase from the
// clamped per-channel sample time and hands over to the bit engine.
// Assumes configuration stays stable while a sequence is running.
module sar_sequencer
    import sar_conv_pkg::*;
#(
    parameter int NCH     = 16,
    parameter int NSEQ    = 4,
    parameter int SMP_W   = 9,
    parameter int SMP_MIN = 3,
    parameter int SMP_MAX = 480,
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int SLOT_W = (NSEQ > 1) ? $clog2(NSEQ) : 1,
    localparam int LEN_W  = $clog2(NSEQ + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [LEN_W-1:0]      seq_len,
    input  logic [NSEQ*CH_W-1:0]  seq_list,
    input  logic [NCH*SMP_W-1:0]  smp_times,
    input  logic                  last_bit,
    output phase_t                phase,
    output logic [CH_W-1:0]       cur_ch,
    output logic                  load,
    output logic                  done
);
    localparam logic [SMP_W-1:0] SMP_LO  = SMP_W'(SMP_MIN);
    localparam logic [SMP_W-1:0] SMP_HI  = SMP_W'(SMP_MAX);
    localparam logic [LEN_W-1:0] LEN_TOP = LEN_W'(NSEQ);

    logic [CH_W-1:0]   slot_ch [NSEQ];
    logic [SMP_W-1:0]  smp_eff [NCH];
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] slot_nxt;
    logic [SMP_W-1:0]  cnt;
    logic [LEN_W-1:0]  eff_len;
    logic              final_slot;

    // Unpack the slot list into channel numbers.
    for (genvar k = 0; k < NSEQ; k++) begin : g_slot
        assign slot_ch[k] = seq_list[k*CH_W +: CH_W];
    end

    // Clamp each channel's sample time into the legal window.
    for (genvar c = 0; c < NCH; c++) begin : g_smp
        logic [SMP_W-1:0] raw;
        assign raw = smp_times[c*SMP_W +: SMP_W];
        assign smp_eff[c] = (raw < SMP_LO) ? SMP_LO :
                            (raw > SMP_HI) ? SMP_HI : raw;
    end

    // Effective sequence length: zero counts as one, excess saturates.
    always_comb begin
        if (seq_len == '0)          eff_len = LEN_W'(1);
        else if (seq_len > LEN_TOP) eff_len = LEN_TOP;
        else                        eff_len = seq_len;
    end

    assign slot_nxt   = slot + SLOT_W'(1);
    assign final_slot = (LEN_W'(slot) + LEN_W'(1)) >= eff_len;
    assign load       = (phase == PH_SAMPLE) && (cnt == '0);
    assign done       = (phase == PH_RESOLVE) && last_bit;

    // Phase, slot, channel and sample-counter state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            slot   <= '0;
            cnt    <= '0;
            cur_ch <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_SAMPLE;
                        slot   <= '0;
                        cur_ch <= slot_ch[0];
                        cnt    <= smp_eff[slot_ch[0]] - SMP_W'(1);
                    end
                end
                PH_SAMPLE: begin
                    if (cnt == '0) phase <= PH_RESOLVE;
                    else           cnt   <= cnt - SMP_W'(1);
                end
                PH_RESOLVE: begin
                    if (last_bit) begin
                        if (final_slot) begin
                            phase <= PH_IDLE;
                        end else begin
                            phase  <= PH_SAMPLE;
                            slot   <= slot_nxt;
                            cur_ch <= slot_ch[slot_nxt];
                            cnt    <= smp_eff[slot_ch[slot_nxt]] - SMP_W'(1);
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_bit_engine.sv
// Bitwise search register: loads the half-scale trial, then on each step keeps
// or drops the bit under test and arms the next lower one. Assumes load and
// step never coincide.
module sar_bit_engine #(
    parameter int RES_W   = 12,
    localparam int IDX_W  = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             cmp_in,
    output logic [RES_W-1:0] code,
    output logic             last_bit,
    output logic [RES_W-1:0] final_code
);
    localparam logic [RES_W-1:0] HALF  = RES_W'(1) << (RES_W - 1);
    localparam logic [IDX_W-1:0] TOP_I = IDX_W'(RES_W - 1);

    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] bit_mask;

    assign bit_mask   = RES_W'(1) << idx;
    assign last_bit   = (idx == '0);
    assign final_code = cmp_in ? code : (code & ~bit_mask);

    // Trial register update: load half scale, then resolve one bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
            idx  <= '0;
        end else if (load) begin
            code <= HALF;
            idx  <= TOP_I;
        end else if (step) begin
            if (idx != '0) begin
                code <= (final_code | (bit_mask >> 1));
                idx  <= idx - IDX_W'(1);
            end else begin
                code <= final_code;
            end
        end
    end
endmodule

// File: rtl/sar_eoc_flags.sv
// Result register with end-of-conversion and overrun flags. A completion wins
// over a clear in the same cycle. Assumes done is a single-cycle pulse.
module sar_eoc_flags #(
    parameter int RES_W = 12,
    parameter int CH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [RES_W-1:0] final_code,
    input  logic [CH_W-1:0]  cur_ch,
    input  logic             rd_result,
    input  logic             eoc_clr,
    output logic [RES_W-1:0] result,
    output logic [CH_W-1:0]  result_ch,
    output logic             eoc,
    output logic             ovr
);
    logic clr_any;
    assign clr_any = rd_result | eoc_clr;

    // Capture the finished code and its channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            result_ch <= '0;
        end else if (done) begin
            result    <= final_code;
            result_ch <= cur_ch;
        end
    end

    // End-of-conversion flag: set on completion, else cleared by either strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       eoc <= 1'b0;
        else if (done)    eoc <= 1'b1;
        else if (clr_any) eoc <= 1'b0;
    end

    // Sticky overrun: unread result overwritten; only the clear strobe drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ovr <= 1'b0;
        else if (done && eoc && !clr_any)   ovr <= 1'b1;
        else if (eoc_clr)                   ovr <= 1'b0;
    end
endmodule

// File: rtl/sar_conv_ctrl.sv
// Top of the successive-approximation conversion sequencer: start-source
// selection, per-channel sample timing, ordered scan and bitwise search with
// result flags. Assumes an external DAC and comparator settle within a cycle.
module sar_conv_ctrl
    import sar_conv_pkg::*;
#(
    parameter int RES_W   = 12,
    parameter int NCH     = 16,
    parameter int NSEQ    = 4,
    parameter int SMP_W   = 9,
    parameter int SMP_MIN = 3,
    parameter int SMP_MAX = 480,
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int LEN_W  = $clog2(NSEQ + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_trig_src,
    input  logic                 sw_start,
    input  logic                 tmr_evt,
    input  logic                 ext_trig,
    input  logic [LEN_W-1:0]     cfg_seq_len,
    input  logic [NSEQ*CH_W-1:0] cfg_seq_list,
    input  logic [NCH*SMP_W-1:0] cfg_smp_time,
    input  logic                 cmp_in,
    input  logic                 rd_result,
    input  logic                 eoc_clr,
    output logic                 sh_hold,
    output logic [RES_W-1:0]     dac_code,
    output logic [CH_W-1:0]      ch_sel,
    output logic                 busy,
    output logic                 eoc,
    output logic                 ovr,
    output logic [RES_W-1:0]     result,
    output logic [CH_W-1:0]      result_ch
);
    phase_t           phase;
    logic             start;
    logic             load;
    logic             conv_done;
    logic             last_bit;
    logic [RES_W-1:0] final_code;

    assign busy    = (phase != PH_IDLE);
    assign sh_hold = (phase == PH_SAMPLE);

    sar_trig_mux u_trig (
        .src_sel  (cfg_trig_src),
        .sw_start (sw_start),
        .tmr_evt  (tmr_evt),
        .ext_trig (ext_trig),
        .idle     (!busy),
        .start    (start)
    );

    sar_sequencer #(
        .NCH(NCH), .NSEQ(NSEQ), .SMP_W(SMP_W),
        .SMP_MIN(SMP_MIN), .SMP_MAX(SMP_MAX)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .seq_len   (cfg_seq_len),
        .seq_list  (cfg_seq_list),
        .smp_times (cfg_smp_time),
        .last_bit  (last_bit),
        .phase     (phase),
        .cur_ch    (ch_sel),
        .load      (load),
        .done      (conv_done)
    );

    sar_bit_engine #(.RES_W(RES_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (phase == PH_RESOLVE),
        .cmp_in     (cmp_in),
        .code       (dac_code),
        .last_bit   (last_bit),
        .final_code (final_code)
    );

    sar_eoc_flags #(.RES_W(RES_W), .CH_W(CH_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (conv_done),
        .final_code (final_code),
        .cur_ch     (ch_sel),
        .rd_result  (rd_result),
        .eoc_clr    (eoc_clr),
        .result     (result),
        .result_ch  (result_ch),
        .eoc        (eoc),
        .ovr        (ovr)
    );
endmodule

// File: rtl/sar_conv_chk.sv
// Property checker for the conversion sequencer, bound to the top module.
// Assumes the synchronous active-low reset is held from time zero.
module sar_conv_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sh_hold,
    input logic             busy,
    input logic [RES_W-1:0] dac_code,
    input logic             eoc,
    input logic             ovr,
    input logic             rd_result,
    input logic             eoc_clr,
    input logic             conv_done
);
    localparam logic [RES_W-1:0] HALF = RES_W'(1) << (RES_W - 1);

    // R1: a sequence always opens with the sample phase.
    p_sample_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sh_hold);

    // R3: the first decision cycle presents the half-scale trial.
    p_msb_trial_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sh_hold && $past(sh_hold)) |-> (dac_code == HALF));

    // R3: each decision adds at most one set bit to the trial code.
    p_bit_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sh_hold && $past(busy) && !$past(sh_hold)) |->
        ($countones(dac_code) <= $countones($past(dac_code)) + 1));

    // R6: busy only drops right after a completed conversion.
    p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(conv_done));

    // R8: a completion always leaves the flag raised.
    p_eoc_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> eoc);

    // R9: overrun rises only over an unread result.
    p_ovr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> ($past(eoc) && $past(conv_done)));

    // R9: the clear strobe always leaves overrun low.
    p_clr_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_clr |=> !ovr);

    // R10: a read coinciding with completion keeps the flag and overrun state.
    p_coincide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && rd_result && !eoc_clr) |=> (eoc && $stable(ovr)));
endmodule

bind sar_conv_ctrl sar_conv_chk #(.RES_W(RES_W)) u_sar_conv_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sh_hold   (sh_hold),
    .busy      (busy),
    .dac_code  (dac_code),
    .eoc       (eoc),
    .ovr       (ovr),
    .rd_result (rd_result),
    .eoc_clr   (eoc_clr),
    .conv_done (conv_done)
);

// File: tb/test_sar_conv_ctrl.sv
// Directed bench for the conversion sequencer with a behavioural comparator.
module test_sar_conv_ctrl;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_trig_src = 2'd0;
    logic        sw_start = 1'b0, tmr_evt = 1'b0, ext_trig = 1'b0;
    logic [2:0]  cfg_seq_len = 3'd1;
    logic [15:0] cfg_seq_list = '0;
    logic [143:0] cfg_smp_time = '0;
    logic        cmp_in;
    logic        rd_result = 1'b0, eoc_clr = 1'b0;
    logic        sh_hold, busy, eoc, ovr;
    logic [11:0] dac_code, result;
    logic [3:0]  ch_sel, result_ch;

    logic [11:0] vin [16];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    // Ideal comparator on the held input of the selected channel.
    assign cmp_in = (vin[ch_sel] >= dac_code);

    sar_conv_ctrl i_sar_conv_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_trig_src(cfg_trig_src),
        .sw_start(sw_start), .tmr_evt(tmr_evt), .ext_trig(ext_trig),
        .cfg_seq_len(cfg_seq_len), .cfg_seq_list(cfg_seq_list),
        .cfg_smp_time(cfg_smp_time), .cmp_in(cmp_in),
        .rd_result(rd_result), .eoc_clr(eoc_clr),
        .sh_hold(sh_hold), .dac_code(dac_code), .ch_sel(ch_sel),
        .busy(busy), .eoc(eoc), .ovr(ovr),
        .result(result), .result_ch(result_ch)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Pulse one start line (0 soft, 1 timer, 2 external) for one cycle.
    task automatic fire(input int which);
        @(negedge clk);
        sw_start = (which == 0);
        tmr_evt  = (which == 1);
        ext_trig = (which == 2);
        @(negedge clk);
        sw_start = 1'b0; tmr_evt = 1'b0; ext_trig = 1'b0;
    endtask

    // Follow a running sequence; optional read and extra start at given counts.
    task automatic watch(input int rd_at, input int trig_at,
                         output int nbusy, output int nsh, output int first);
        bit got = 1'b0;
        nbusy = 0; nsh = 0; first = -1;
        while (busy && nbusy < 2000) begin
            nbusy++;
            if (sh_hold) nsh++;
            else if (!got) begin first = int'(dac_code); got = 1'b1; end
            rd_result = (nbusy == rd_at);
            sw_start  = (nbusy == trig_at);
            @(negedge clk);
        end
        rd_result = 1'b0;
        sw_start  = 1'b0;
    endtask

    task automatic pulse_clear(input bit use_rd);
        @(negedge clk);
        if (use_rd) rd_result = 1'b1; else eoc_clr = 1'b1;
        @(negedge clk);
        rd_result = 1'b0; eoc_clr = 1'b0;
    endtask

    task automatic single_setup(input int ch, input int smp, input int v);
        cfg_seq_len = 3'd1;
        cfg_seq_list[3:0] = 4'(ch);
        cfg_smp_time[ch*9 +: 9] = 9'(smp);
        vin[ch] = 12'(v);
    endtask

    task automatic t_reset();
        chk(busy == 0, "R6 reset busy", int'(busy), 0);
        chk(eoc == 0, "R8 reset eoc", int'(eoc), 0);
        chk(ovr == 0, "R9 reset ovr", int'(ovr), 0);
        chk(sh_hold == 0, "R1 reset sh_hold", int'(sh_hold), 0);
    endtask

    task automatic t_single();
        int nb, ns, fc;
        single_setup(5, 3, 2047);
        cfg_trig_src = 2'd0;
        fire(0);
        chk(ch_sel == 4'd5, "R1 ch_sel during sample", int'(ch_sel), 5);
        watch(0, 0, nb, ns, fc);
        chk(ns == 3, "R1 sample cycles", ns, 3);
        chk(fc == 12'h800, "R3 first trial", fc, 2048);
        chk(nb == 15, "R4 busy cycles", nb, 15);
        chk(result == 12'd2047, "R4 result", int'(result), 2047);
        chk(result_ch == 4'd5, "R8 result_ch", int'(result_ch), 5);
        chk(eoc == 1, "R8 eoc set", int'(eoc), 1);
        pulse_clear(1'b0);
        chk(eoc == 0, "R8 eoc_clr clears", int'(eoc), 0);
    endtask

    task automatic t_corners();
        int vals[5] = '{0, 4095, 1, 2048, 2730};
        int nb, ns, fc;
        foreach (vals[i]) begin
            single_setup(3, 4, vals[i]);
            fire(0);
            watch(0, 0, nb, ns, fc);
            chk(result == 12'(vals[i]), "R4 corner result", int'(result), vals[i]);
            chk(nb == 16, "R4 corner busy", nb, 16);
            pulse_clear(1'b1);
            chk(eoc == 0, "R8 rd_result clears", int'(eoc), 0);
        end
    endtask

    task automatic t_clamp();
        int smp[4] = '{1, 0, 500, 10};
        int exp_s[4] = '{3, 3, 480, 10};
        int nb, ns, fc;
        foreach (smp[i]) begin
            single_setup(9, smp[i], 1234);
            fire(0);
            watch(0, 0, nb, ns, fc);
            chk(ns == exp_s[i], "R2 clamped sample time", ns, exp_s[i]);
            chk(nb == exp_s[i] + 12, "R4 total with clamp", nb, exp_s[i] + 12);
            pulse_clear(1'b0);
        end
    endtask

    task automatic t_trig();
        int nb, ns, fc;
        single_setup(1, 3, 777);
        cfg_trig_src = 2'd1;
        fire(0);
        chk(busy == 0, "R5 soft ignored on timer select", int'(busy), 0);
        fire(2);
        chk(busy == 0, "R5 ext ignored on timer select", int'(busy), 0);
        fire(1);
        chk(busy == 1, "R5 timer starts", int'(busy), 1);
        watch(0, 0, nb, ns, fc);
        pulse_clear(1'b0);
        cfg_trig_src = 2'd2;
        fire(1);
        chk(busy == 0, "R5 timer ignored on ext select", int'(busy), 0);
        fire(2);
        chk(busy == 1, "R5 ext starts", int'(busy), 1);
        watch(0, 0, nb, ns, fc);
        chk(result == 12'd777, "R5 ext result", int'(result), 777);
        pulse_clear(1'b0);
        cfg_trig_src = 2'd3;
        fire(0); fire(1); fire(2);
        chk(busy == 0 && eoc == 0, "R5 none selected", int'(busy), 0);
        cfg_trig_src = 2'd0;
    endtask

    task automatic t_busy_ignore();
        int nb, ns, fc;
        single_setup(4, 6, 300);
        fire(0);
        watch(0, 9, nb, ns, fc);
        chk(nb == 18, "R6 busy continuous, restart ignored", nb, 18);
        @(negedge clk); @(negedge clk);
        chk(busy == 0, "R6 no restart after trigger during busy", int'(busy), 0);
        pulse_clear(1'b0);
    endtask

    task automatic t_scan();
        int nb, nseen;
        int got_ch[4];
        int got_v[4];
        cfg_seq_list = {4'd9, 4'd0, 4'd7, 4'd2};
        cfg_seq_len = 3'd3;
        cfg_smp_time[2*9 +: 9] = 9'd5; vin[2] = 12'd100;
        cfg_smp_time[7*9 +: 9] = 9'd3; vin[7] = 12'd3000;
        cfg_smp_time[0*9 +: 9] = 9'd8; vin[0] = 12'd4001;
        fire(0);
        nb = 0; nseen = 0;
        while (busy && nb < 2000) begin
            nb++;
            rd_result = 1'b0;
            if (eoc && nseen < 4) begin
                got_ch[nseen] = int'(result_ch); got_v[nseen] = int'(result);
                nseen++; rd_result = 1'b1;
            end
            @(negedge clk);
        end
        rd_result = 1'b0;
        if (eoc && nseen < 4) begin
            got_ch[nseen] = int'(result_ch); got_v[nseen] = int'(result); nseen++;
        end
        chk(nb == 52, "R7 scan busy cycles", nb, 52);
        chk(nseen == 3, "R7 scan result count", nseen, 3);
        chk(got_ch[0] == 2 && got_v[0] == 100, "R7 slot0", got_ch[0], 2);
        chk(got_ch[1] == 7 && got_v[1] == 3000, "R7 slot1", got_ch[1], 7);
        chk(got_ch[2] == 0 && got_v[2] == 4001, "R7 slot2", got_ch[2], 0);
        pulse_clear(1'b0);
        cfg_seq_len = 3'd0;
        fire(0);
        watch(0, 0, nb, nseen, got_v[3]);
        chk(nb == 17 && result_ch == 4'd2, "R7 zero length is single", nb, 17);
        pulse_clear(1'b0);
    endtask

    task automatic t_overrun();
        int nb, ns, fc;
        single_setup(6, 3, 50);
        fire(0); watch(0, 0, nb, ns, fc);
        vin[6] = 12'd60;
        fire(0); watch(0, 0, nb, ns, fc);
        chk(ovr == 1, "R9 overrun set", int'(ovr), 1);
        chk(result == 12'd60, "R9 newest result kept", int'(result), 60);
        pulse_clear(1'b1);
        chk(ovr == 1, "R9 read leaves overrun", int'(ovr), 1);
        pulse_clear(1'b0);
        chk(ovr == 0 && eoc == 0, "R9 clear drops overrun", int'(ovr), 0);
    endtask

    task automatic t_coincide();
        int nb, ns, fc;
        single_setup(8, 4, 900);
        fire(0); watch(0, 0, nb, ns, fc);
        vin[8] = 12'd901;
        fire(0); watch(16, 0, nb, ns, fc);
        chk(eoc == 1, "R10 eoc kept on coincident read", int'(eoc), 1);
        chk(ovr == 0, "R10 no overrun on coincident read", int'(ovr), 0);
        chk(result == 12'd901, "R10 new result", int'(result), 901);
        pulse_clear(1'b0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 16; i++) vin[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_corners();
        t_clamp();
        t_trig();
        t_busy_ignore();
        t_scan();
        t_overrun();
        t_coincide();
        summary();
    end
endmodule